// File: doc/BRIEF.md
# Contiguous Access Merging Buffer

This block gathers a run of narrow memory fragments into one access of at most 16 bytes. The first fragment after the buffer is empty sets the start address, the access kind and the exclusive flag. Each later fragment must begin at the byte just past the data already held and must carry the same kind and flag. Its bytes are stacked above the bytes already held.

A flush request turns the collected bytes into one registered output transaction. That transaction carries the start address, the byte count, an issue command and the merged data. A read flush states how many bytes it expects, and on a read the bytes can be mirrored for big-endian operation. Once the consumer accepts the transaction, the buffer is empty and ready for a new run.

Any fragment or flush that breaks the rules sets a sticky error flag and leaves the held state as it was. The error flag clears only on reset.

Top module: `mb_merge_buf`

## Requirements
- R1: After reset, `out_valid` and `err` are 0 and the buffer is empty, so the first fragment at any address is accepted.
- R2: A fragment arriving at an empty buffer stores its address, kind and exclusive flag. Only its low 2^`frag_size_code` bytes are kept, and the data bytes above its size are cleared to zero.
- R3: A fragment whose address equals the start address plus the held byte count, with the same kind and exclusive flag, is accepted. Its bytes are placed directly above the held bytes and the held count grows by its size.
- R4: A fragment is rejected when its address is not contiguous, its kind or exclusive flag differs, its `frag_size_code` is above 4, or the new total would exceed 16 bytes. A rejected fragment sets `err` and leaves the held contents unchanged.
- R5: An accepted flush raises `out_valid` on the next clock edge. It presents the start address on `out_addr`, the held byte count on `out_bytes` and the merged data on `out_data`.
- R6: A read flush (`flush_rd`=1) is accepted only when `flush_bytes` equals the held count. Otherwise it sets `err`, issues nothing and keeps the buffer.
- R7: A read flush with `big_endian`=1 mirrors the byte order within the low `out_bytes` bytes. Write flushes are never mirrored.
- R8: Kind codes are normal=0, stream=1, unprivileged=2, ordered=3 and atomic=4. The command codes `out_cmd` are as follows. For non-exclusive reads, normal and unprivileged give 0, stream gives 1 and ordered gives 2. For exclusive reads, atomic gives 3 and ordered gives 4. Every non-exclusive write gives 5 and every exclusive write gives 6.
- R9: A flush is rejected and sets `err` in three cases: its `flush_excl` differs from the held exclusive flag, the held flag is set with a kind other than atomic or ordered, or the held flag is clear with kind atomic.
- R10: A flush whose held count is not 1, 2, 4, 8 or 16 is rejected and sets `err`.
- R11: While `out_valid`=1 and `out_ready`=0, all outputs hold steady and fragments and flushes are ignored. After the handshake edge the buffer is empty.
- R12: A flush of an empty buffer sets `err` and issues nothing.
- R13: When a fragment and a flush arrive in the same cycle, the fragment is handled and the flush is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frag_valid | input | 1 | Fragment present this cycle |
| frag_addr | input | ADDR_W | Byte address of the fragment |
| frag_size_code | input | 3 | log2 of the fragment byte count |
| frag_kind | input | 3 | Access kind code |
| frag_excl | input | 1 | Exclusive flag of the fragment |
| frag_data | input | 128 | Fragment data, low bytes significant |
| flush_req | input | 1 | Request to issue the held access |
| flush_rd | input | 1 | 1 = read flush, 0 = write flush |
| flush_excl | input | 1 | Exclusive flag declared by the flush |
| flush_bytes | input | 5 | Byte count expected by a read flush |
| big_endian | input | 1 | Mirror byte order on read flushes |
| out_ready | input | 1 | Consumer accepts the output transaction |
| out_valid | output | 1 | Output transaction present |
| out_addr | output | ADDR_W | Start address of the transaction |
| out_bytes | output | 5 | Byte count of the transaction |
| out_cmd | output | 3 | Issue command code |
| out_data | output | 128 | Merged (and possibly mirrored) data |
| err | output | 1 | Sticky protocol error |

## Verification
The merge path is exercised with several fragment sequences. A lone fragment carrying junk above its size shows whether masking works. Two 4-byte pieces show whether stacking is done in the right order, and a descending 8+4+2+1+1 chain that fills all 16 bytes shows whether growth reaches the limit without overflow. Each illegal pattern is run from a fresh reset and then flushed, so the buffer is shown to be untouched: a gap, a kind change, an exclusive change, an oversize code and an overflow. Read and write flushes of the same bytes with `big_endian` set separate mirroring from plain issue, and one pass per kind/exclusive pairing covers every command code. A stalled consumer, a same-cycle fragment and flush, and a reuse right after a handshake probe the ordering rules.

// File: rtl/mb_pkg.sv
package mb_pkg;

   typedef enum logic [2:0] {
      K_NORMAL  = 3'd0,
      K_STREAM  = 3'd1,
      K_UNPRIV  = 3'd2,
      K_ORDERED = 3'd3,
      K_ATOMIC  = 3'd4
   } acc_kind_e;

   typedef enum logic [2:0] {
      C_RD_NORMAL   = 3'd0,
      C_RD_STREAM   = 3'd1,
      C_RD_ACQUIRE  = 3'd2,
      C_RD_EXCL     = 3'd3,
      C_RD_EXCL_ACQ = 3'd4,
      C_WR_NORMAL   = 3'd5,
      C_WR_EXCL     = 3'd6
   } issue_cmd_e;

endpackage

// File: rtl/mb_frag_merge.sv
module mb_frag_merge #(
   parameter int ADDR_W    = 32,
   parameter int MAX_BYTES = 16,
   localparam int DATA_W   = MAX_BYTES * 8,
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int MAX_CODE = $clog2(MAX_BYTES),
   localparam int CODE_W   = $clog2(MAX_CODE + 1)
) (
   input  logic [LEN_W-1:0]      held_bytes,
   input  logic [ADDR_W-1:0]     base_addr,
   input  mb_pkg::acc_kind_e     held_kind,
   input  logic                  held_excl,
   input  logic [DATA_W-1:0]     held_data,
   input  logic [ADDR_W-1:0]     frag_addr,
   input  logic [CODE_W-1:0]     frag_code,
   input  mb_pkg::acc_kind_e     frag_kind,
   input  logic                  frag_excl,
   input  logic [DATA_W-1:0]     frag_data,
   output logic                  merge_ok,
   output logic [LEN_W-1:0]      nxt_bytes,
   output logic [DATA_W-1:0]     nxt_data
);

   logic [LEN_W:0]    frag_len;
   logic [LEN_W:0]    sum;
   logic              code_ok, empty, same_attr, addr_next, fits;
   logic [DATA_W-1:0] masked;

   assign code_ok   = frag_code <= CODE_W'(MAX_CODE);
   assign frag_len  = code_ok ? ((LEN_W+1)'(1) << frag_code) : '0;
   assign sum       = {1'b0, held_bytes} + frag_len;
   assign empty     = held_bytes == '0;
   assign same_attr = (frag_kind == held_kind) && (frag_excl == held_excl);
   assign addr_next = frag_addr == (base_addr + ADDR_W'(held_bytes));
   assign fits      = sum <= (LEN_W+1)'(MAX_BYTES);

   for (genvar b = 0; b < MAX_BYTES; b++) begin : g_mask
      assign masked[8*b +: 8] = ((LEN_W+1)'(b) < frag_len) ? frag_data[8*b +: 8] : 8'h00;
   end

   assign merge_ok  = code_ok && (empty || (same_attr && addr_next && fits));
   assign nxt_bytes = sum[LEN_W-1:0];
   assign nxt_data  = empty ? masked : (held_data | (masked << {held_bytes, 3'b000}));

endmodule

// File: rtl/mb_byte_swap.sv
module mb_byte_swap #(
   parameter int MAX_BYTES = 16,
   localparam int DATA_W   = MAX_BYTES * 8,
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int NSZ      = $clog2(MAX_BYTES) + 1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LEN_W-1:0]  nbytes,
   output logic [DATA_W-1:0] dout
);

   logic [NSZ-1:0][DATA_W-1:0] variant;

   for (genvar s = 0; s < NSZ; s++) begin : g_sz
      localparam int NB = 1 << s;
      for (genvar b = 0; b < NB; b++) begin : g_b
         assign variant[s][8*b +: 8] = din[8*(NB-1-b) +: 8];
      end
      if (NB < MAX_BYTES) begin : g_pad
         assign variant[s][DATA_W-1:8*NB] = '0;
      end
   end

   always_comb begin
      dout = din;
      for (int s = 0; s < NSZ; s++) begin
         if (nbytes == LEN_W'(1 << s)) dout = variant[s];
      end
   end

endmodule

// File: rtl/mb_issue_decode.sv
module mb_issue_decode (
   input  mb_pkg::acc_kind_e  kind,
   input  logic               excl,
   input  logic               rd,
   output logic               legal,
   output mb_pkg::issue_cmd_e cmd
);
   import mb_pkg::*;

   always_comb begin
      legal = 1'b0;
      cmd   = C_RD_NORMAL;
      if (excl) begin
         legal = (kind == K_ATOMIC) || (kind == K_ORDERED);
         if (!rd)                   cmd = C_WR_EXCL;
         else if (kind == K_ORDERED) cmd = C_RD_EXCL_ACQ;
         else                       cmd = C_RD_EXCL;
      end else begin
         legal = (kind == K_NORMAL) || (kind == K_STREAM) ||
                 (kind == K_UNPRIV) || (kind == K_ORDERED);
         if (!rd)                    cmd = C_WR_NORMAL;
         else if (kind == K_STREAM)  cmd = C_RD_STREAM;
         else if (kind == K_ORDERED) cmd = C_RD_ACQUIRE;
         else                        cmd = C_RD_NORMAL;
      end
   end

endmodule

// File: rtl/mb_merge_buf.sv
module mb_merge_buf #(
   parameter int ADDR_W    = 32,
   parameter int MAX_BYTES = 16,
   localparam int DATA_W   = MAX_BYTES * 8,
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int CODE_W   = $clog2($clog2(MAX_BYTES) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frag_valid,
   input  logic [ADDR_W-1:0] frag_addr,
   input  logic [CODE_W-1:0] frag_size_code,
   input  logic [2:0]        frag_kind,
   input  logic              frag_excl,
   input  logic [DATA_W-1:0] frag_data,
   input  logic              flush_req,
   input  logic              flush_rd,
   input  logic              flush_excl,
   input  logic [LEN_W-1:0]  flush_bytes,
   input  logic              big_endian,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic [LEN_W-1:0]  out_bytes,
   output logic [2:0]        out_cmd,
   output logic [DATA_W-1:0] out_data,
   output logic              err
);
   import mb_pkg::*;

   if (MAX_BYTES < 2 || (MAX_BYTES & (MAX_BYTES - 1)) != 0) begin : g_bad_size
      $error("MAX_BYTES must be a power of two of at least 2");
   end
   if (ADDR_W < LEN_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the byte count");
   end

   logic [LEN_W-1:0]  held_bytes;
   logic [ADDR_W-1:0] base_addr;
   acc_kind_e         held_kind;
   logic              held_excl;
   logic [DATA_W-1:0] held_data;

   logic              merge_ok;
   logic [LEN_W-1:0]  nxt_bytes;
   logic [DATA_W-1:0] nxt_data;
   logic [DATA_W-1:0] swapped;
   logic              kind_legal;
   issue_cmd_e        cmd;
   logic              pow2, flush_ok;

   mb_frag_merge #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_merge (
      .held_bytes (held_bytes),
      .base_addr  (base_addr),
      .held_kind  (held_kind),
      .held_excl  (held_excl),
      .held_data  (held_data),
      .frag_addr  (frag_addr),
      .frag_code  (frag_size_code),
      .frag_kind  (acc_kind_e'(frag_kind)),
      .frag_excl  (frag_excl),
      .frag_data  (frag_data),
      .merge_ok   (merge_ok),
      .nxt_bytes  (nxt_bytes),
      .nxt_data   (nxt_data)
   );

   mb_byte_swap #(.MAX_BYTES(MAX_BYTES)) u_swap (
      .din    (held_data),
      .nbytes (held_bytes),
      .dout   (swapped)
   );

   mb_issue_decode u_dec (
      .kind  (held_kind),
      .excl  (held_excl),
      .rd    (flush_rd),
      .legal (kind_legal),
      .cmd   (cmd)
   );

   assign pow2     = (held_bytes != '0) && ((held_bytes & (held_bytes - 1'b1)) == '0);
   assign flush_ok = pow2 && (flush_excl == held_excl) && kind_legal &&
                     (!flush_rd || (flush_bytes == held_bytes));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_bytes <= '0;
         base_addr  <= '0;
         held_kind  <= K_NORMAL;
         held_excl  <= 1'b0;
         held_data  <= '0;
         out_valid  <= 1'b0;
         out_addr   <= '0;
         out_bytes  <= '0;
         out_cmd    <= '0;
         out_data   <= '0;
         err        <= 1'b0;
      end else if (out_valid) begin
         if (out_ready) begin
            out_valid  <= 1'b0;
            held_bytes <= '0;
            held_data  <= '0;
         end
      end else if (frag_valid) begin
         if (merge_ok) begin
            if (held_bytes == '0) begin
               base_addr <= frag_addr;
               held_kind <= acc_kind_e'(frag_kind);
               held_excl <= frag_excl;
            end
            held_bytes <= nxt_bytes;
            held_data  <= nxt_data;
         end else begin
            err <= 1'b1;
         end
      end else if (flush_req) begin
         if (flush_ok) begin
            out_valid <= 1'b1;
            out_addr  <= base_addr;
            out_bytes <= held_bytes;
            out_cmd   <= cmd;
            out_data  <= (flush_rd && big_endian) ? swapped : held_data;
         end else begin
            err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mb_merge_buf_chk.sv
module mb_merge_buf_chk #(
   parameter int ADDR_W    = 32,
   parameter int MAX_BYTES = 16,
   localparam int DATA_W   = MAX_BYTES * 8,
   localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              out_valid,
   input logic              out_ready,
   input logic [ADDR_W-1:0] out_addr,
   input logic [LEN_W-1:0]  out_bytes,
   input logic [2:0]        out_cmd,
   input logic [DATA_W-1:0] out_data,
   input logic              err,
   input logic [LEN_W-1:0]  held_bytes
);

   // R11: a stalled transaction keeps every field
   a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_addr)
                                  && $stable(out_bytes) && $stable(out_cmd));

   // R11: the buffer is empty right after the handshake
   a_r11_empty_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid && (held_bytes == '0));

   // R4: the error flag never clears on its own
   a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   // R10: an issued count is always one of the legal sizes
   a_r10_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $countones(out_bytes) == 1);

   // R3: accumulation never passes the capacity
   a_r3_bound: assert property (@(posedge clk) disable iff (!rst_n)
      held_bytes <= LEN_W'(MAX_BYTES));

   // R8: only defined command codes are issued
   a_r8_cmd_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_cmd <= 3'd6);

endmodule

bind mb_merge_buf mb_merge_buf_chk #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_addr   (out_addr),
   .out_bytes  (out_bytes),
   .out_cmd    (out_cmd),
   .out_data   (out_data),
   .err        (err),
   .held_bytes (held_bytes)
);

// File: tb/sim_mb_merge_buf.sv
`timescale 1ns/1ps
module sim_mb_merge_buf;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frag_valid = 1'b0;
   logic [31:0]  frag_addr = '0;
   logic [2:0]   frag_size_code = '0;
   logic [2:0]   frag_kind = '0;
   logic         frag_excl = 1'b0;
   logic [127:0] frag_data = '0;
   logic         flush_req = 1'b0;
   logic         flush_rd = 1'b0;
   logic         flush_excl = 1'b0;
   logic [4:0]   flush_bytes = '0;
   logic         big_endian = 1'b0;
   logic         out_ready = 1'b1;
   logic         out_valid;
   logic [31:0]  out_addr;
   logic [4:0]   out_bytes;
   logic [2:0]   out_cmd;
   logic [127:0] out_data;
   logic         err;

   int n_chk = 0;
   int n_err = 0;

   typedef struct {
      logic [31:0]  a;
      logic [4:0]   n;
      logic [2:0]   c;
      logic [127:0] d;
      string        tag;
   } exp_t;
   exp_t q[$];

   always #10 clk = ~clk;

   mb_merge_buf u0 (
      .clk(clk), .rst_n(rst_n), .frag_valid(frag_valid), .frag_addr(frag_addr),
      .frag_size_code(frag_size_code), .frag_kind(frag_kind), .frag_excl(frag_excl),
      .frag_data(frag_data), .flush_req(flush_req), .flush_rd(flush_rd),
      .flush_excl(flush_excl), .flush_bytes(flush_bytes), .big_endian(big_endian),
      .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
      .out_bytes(out_bytes), .out_cmd(out_cmd), .out_data(out_data), .err(err)
   );

   task automatic check(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard on every accepted transaction
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (q.size() == 0) begin
            check(1'b0, "R5 unexpected issue", {out_addr, out_bytes, out_cmd, out_data}, '0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(out_addr == e.a && out_bytes == e.n && out_cmd == e.c && out_data == e.d,
                  e.tag, {out_addr, out_bytes, out_cmd, out_data}, {e.a, e.n, e.c, e.d});
         end
      end
   end

   task automatic expect_tx(input logic [31:0] a, input logic [4:0] n, input logic [2:0] c,
                            input logic [127:0] d, input string tag);
      exp_t e;
      e.a = a; e.n = n; e.c = c; e.d = d; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic frag(input logic [31:0] a, input logic [2:0] code, input logic [2:0] k,
                       input logic x, input logic [127:0] d);
      @(negedge clk);
      frag_addr = a; frag_size_code = code; frag_kind = k; frag_excl = x; frag_data = d;
      frag_valid = 1'b1;
      @(negedge clk);
      frag_valid = 1'b0;
   endtask

   task automatic flush(input logic rd, input logic x, input logic [4:0] n, input logic be);
      @(negedge clk);
      flush_rd = rd; flush_excl = x; flush_bytes = n; big_endian = be;
      flush_req = 1'b1;
      @(negedge clk);
      flush_req = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic set_ready(input logic v);
      @(posedge clk);
      #2 out_ready = v;
   endtask

   task automatic one_shot(input logic [31:0] a, input logic [2:0] code, input logic [2:0] k,
                           input logic x, input logic [127:0] d, input logic rd,
                           input logic [4:0] n, input logic [2:0] c, input string tag);
      expect_tx(a, n, c, d, tag);
      frag(a, code, k, x, d);
      flush(rd, x, n, 1'b0);
      idle(1);
   endtask

   task automatic expect_err(input string tag);
      check(err === 1'b1 && out_valid === 1'b0, tag, {190'd0, err, out_valid}, {190'd0, 2'b10});
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(out_valid === 1'b0 && err === 1'b0, "R1 reset outputs", {190'd0, out_valid, err}, '0);

      // R2 lone fragment, junk above its size dropped; R5 issue fields
      expect_tx(32'h0000_0040, 5'd4, 3'd5, 128'h1122_3344, "R2 R5 single fragment masked");
      frag(32'h0000_0040, 3'd2, 3'd0, 1'b0, 128'hDEAD_BEEF_0BAD_F00D_1234_5678_1122_3344);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R3 two 4-byte pieces stacked, write with big_endian set is not mirrored (R7)
      expect_tx(32'h0000_0200, 5'd8, 3'd5, 128'h5566_7788_1122_3344, "R3 R7 write merge no mirror");
      frag(32'h0000_0200, 3'd2, 3'd0, 1'b0, 128'h1122_3344);
      frag(32'h0000_0204, 3'd2, 3'd0, 1'b0, 128'hFFFF_0000_5566_7788);
      flush(1'b0, 1'b0, 5'd0, 1'b1);
      idle(1);

      // R7 same bytes as a big-endian read
      expect_tx(32'h0000_0200, 5'd8, 3'd0, 128'h4433_2211_8877_6655, "R7 read mirrored 8 bytes");
      frag(32'h0000_0200, 3'd2, 3'd0, 1'b0, 128'h1122_3344);
      frag(32'h0000_0204, 3'd2, 3'd0, 1'b0, 128'h5566_7788);
      flush(1'b1, 1'b0, 5'd8, 1'b1);
      idle(1);

      // R3 fill all 16 bytes, R7 mirrored read of the full width
      expect_tx(32'h0000_1000, 5'd16, 3'd0, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
                "R3 R7 sixteen byte chain");
      frag(32'h0000_1000, 3'd3, 3'd0, 1'b0, 128'h0807_0605_0403_0201);
      frag(32'h0000_1008, 3'd2, 3'd0, 1'b0, 128'h0C0B_0A09);
      frag(32'h0000_100C, 3'd1, 3'd0, 1'b0, 128'h0E0D);
      frag(32'h0000_100E, 3'd0, 3'd0, 1'b0, 128'h0F);
      frag(32'h0000_100F, 3'd0, 3'd0, 1'b0, 128'h10);
      flush(1'b1, 1'b0, 5'd16, 1'b1);
      idle(1);

      // R8 command mapping
      one_shot(32'h900, 3'd3, 3'd3, 1'b1, 128'hA5A5_0000_1111_2222, 1'b1, 5'd8, 3'd4, "R8 excl ordered read");
      one_shot(32'h910, 3'd2, 3'd4, 1'b1, 128'h1357_9BDF, 1'b1, 5'd4, 3'd3, "R8 excl atomic read");
      one_shot(32'h920, 3'd1, 3'd2, 1'b0, 128'h4242, 1'b1, 5'd2, 3'd0, "R8 unpriv read");
      one_shot(32'h930, 3'd1, 3'd3, 1'b0, 128'h6789, 1'b1, 5'd2, 3'd2, "R8 ordered read");
      one_shot(32'h940, 3'd0, 3'd1, 1'b0, 128'h5A, 1'b1, 5'd1, 3'd1, "R8 stream read");
      one_shot(32'h950, 3'd2, 3'd3, 1'b0, 128'hCAFE_0001, 1'b0, 5'd4, 3'd5, "R8 ordered write");
      one_shot(32'h960, 3'd3, 3'd4, 1'b1, 128'h0BAD_CAFE_FEED_FACE, 1'b0, 5'd8, 3'd6, "R8 R9 excl write");

      // R11 stall: outputs steady, fragment ignored, then buffer reusable
      set_ready(1'b0);
      expect_tx(32'h0000_3000, 5'd4, 3'd5, 128'hA1A2_A3A4, "R11 stalled transaction");
      frag(32'h0000_3000, 3'd2, 3'd0, 1'b0, 128'hA1A2_A3A4);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      begin
         logic [127:0] d0;
         d0 = out_data;
         frag(32'h0000_3004, 3'd2, 3'd0, 1'b0, 128'hFFFF_FFFF);
         check(out_valid === 1'b1 && out_data === d0 && err === 1'b0, "R11 hold during stall",
               {63'd0, out_valid, out_data}, {63'd0, 1'b1, d0});
      end
      set_ready(1'b1);
      idle(2);
      expect_tx(32'h0000_5000, 5'd1, 3'd5, 128'h77, "R11 empty after handshake");
      frag(32'h0000_5000, 3'd0, 3'd0, 1'b0, 128'h77);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);
      check(err === 1'b0, "R11 no error on reuse", {191'd0, err}, '0);

      // R13 fragment and flush together
      frag(32'h0000_0080, 3'd1, 3'd0, 1'b0, 128'hBEEF);
      @(negedge clk);
      frag_addr = 32'h82; frag_size_code = 3'd1; frag_kind = 3'd0; frag_excl = 1'b0;
      frag_data = 128'hDEAD; frag_valid = 1'b1;
      flush_rd = 1'b0; flush_excl = 1'b0; flush_req = 1'b1;
      @(negedge clk);
      frag_valid = 1'b0; flush_req = 1'b0;
      check(out_valid === 1'b0 && err === 1'b0, "R13 flush ignored", {190'd0, out_valid, err}, '0);
      expect_tx(32'h0000_0080, 5'd4, 3'd5, 128'hDEAD_BEEF, "R13 fragment kept");
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R4 address gap
      do_reset();
      frag(32'h100, 3'd2, 3'd0, 1'b0, 128'h0102_0304);
      frag(32'h105, 3'd1, 3'd0, 1'b0, 128'hFFFF);
      expect_err("R4 address gap");
      expect_tx(32'h100, 5'd4, 3'd5, 128'h0102_0304, "R4 gap leaves buffer");
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R4 kind change
      do_reset();
      frag(32'h100, 3'd2, 3'd0, 1'b0, 128'h0A0B_0C0D);
      frag(32'h104, 3'd2, 3'd1, 1'b0, 128'hFFFF_FFFF);
      expect_err("R4 kind mismatch");
      expect_tx(32'h100, 5'd4, 3'd5, 128'h0A0B_0C0D, "R4 kind change leaves buffer");
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R4 exclusive change
      do_reset();
      frag(32'h100, 3'd2, 3'd4, 1'b1, 128'h1111_2222);
      frag(32'h104, 3'd2, 3'd4, 1'b0, 128'hFFFF_FFFF);
      expect_err("R4 exclusive mismatch");
      expect_tx(32'h100, 5'd4, 3'd6, 128'h1111_2222, "R4 excl change leaves buffer");
      flush(1'b0, 1'b1, 5'd0, 1'b0);
      idle(1);

      // R4 illegal size code
      do_reset();
      frag(32'h100, 3'd1, 3'd0, 1'b0, 128'h3344);
      frag(32'h102, 3'd5, 3'd0, 1'b0, 128'hFFFF);
      expect_err("R4 size code above 4");
      expect_tx(32'h100, 5'd2, 3'd5, 128'h3344, "R4 bad code leaves buffer");
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R4 overflow beyond 16 bytes
      do_reset();
      frag(32'h0, 3'd4, 3'd0, 1'b0, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F);
      frag(32'h10, 3'd0, 3'd0, 1'b0, 128'hEE);
      expect_err("R4 overflow");
      expect_tx(32'h0, 5'd16, 3'd5, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F,
                "R4 overflow leaves buffer");
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      idle(1);

      // R6 read size mismatch
      do_reset();
      frag(32'h6000, 3'd2, 3'd0, 1'b0, 128'hCAFE_F00D);
      flush(1'b1, 1'b0, 5'd8, 1'b0);
      expect_err("R6 read size mismatch");
      expect_tx(32'h6000, 5'd4, 3'd0, 128'hCAFE_F00D, "R6 matching read after mismatch");
      flush(1'b1, 1'b0, 5'd4, 1'b0);
      idle(1);

      // R10 total of three bytes
      do_reset();
      frag(32'h40, 3'd0, 3'd0, 1'b0, 128'h01);
      frag(32'h41, 3'd1, 3'd0, 1'b0, 128'h0302);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      expect_err("R10 three byte total");

      // R9 non-exclusive flush of exclusive buffer
      do_reset();
      frag(32'h800, 3'd3, 3'd4, 1'b1, 128'h1234);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      expect_err("R9 excl flag mismatch at flush");

      // R9 atomic kind without exclusive flag
      do_reset();
      frag(32'h800, 3'd2, 3'd4, 1'b0, 128'h1234);
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      expect_err("R9 atomic without exclusive");

      // R12 flush of empty buffer
      do_reset();
      flush(1'b0, 1'b0, 5'd0, 1'b0);
      expect_err("R12 empty flush");

      idle(4);
      check(q.size() == 0, "R5 all expected transactions issued", 192'(q.size()), '0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule